// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block resolves a translation miss. It takes a walk request that carries a modified virtual address and the current translation table base. It then reads descriptors from the table through a single-word memory read port. Every walk starts with a first-level fetch. The type of that descriptor decides what happens next:

- a 1MB section finishes the walk at once;
- a pointer to a coarse or fine second-level table causes one more fetch;
- an invalid entry ends the walk with a section fault.

When the walk finishes, the block returns everything needed to fill a translation buffer entry in one pulse. This covers the physical page base and the full physical address, a size code, the domain, four quarter permission fields together with the field selected for this address, and the cacheable and bufferable bits. A fault code is returned in place of these when the walk fails. Domain checks and the buffer itself belong to the surrounding logic.

Top module: `ptw_walker`

## Requirements
- R1: After reset `busy`, `done` and `mem_req` are all low.
- R2: A `walk_req` seen while idle is accepted. In the next cycle `mem_req` is high and `mem_addr` equals `{tbase[31:14], walk_va[31:20], 2'b00}`.
- R3: While `mem_req` is high and `mem_rvalid` is low, `mem_req` stays high and `mem_addr` does not change in the following cycle.
- R4: A first-level descriptor with bits [1:0] = 00 ends the walk with `res_fault` = 01 (section fault). No second fetch is made, and every result field other than `res_fault` is zero.
- R5: A first-level descriptor with bits [1:0] = 10 is a section, and the walk ends after one fetch with these results:
  - `res_size` = 00;
  - `res_base` = descriptor bits [31:20] followed by 20 zero bits;
  - `res_pa` = that base joined with `walk_va[19:0]`;
  - `res_domain` = descriptor bits [8:5];
  - all four `res_perm_all` fields and `res_perm` = descriptor bits [11:10];
  - `res_c` = bit 3 and `res_b` = bit 2.
- R6: First-level bits [1:0] = 01 (coarse table) cause a second fetch at `{desc[31:10], walk_va[19:12], 2'b00}`. First-level bits [1:0] = 11 (fine table) cause a second fetch at `{desc[31:12], walk_va[19:10], 2'b00}`.
- R7: A second-level descriptor with bits [1:0] = 00 ends the walk with `res_fault` = 10 (page fault). A second-level descriptor with bits [1:0] = 11 read from a coarse table also ends with a page fault. In both cases all other result fields are zero.
- R8: Second-level bits [1:0] select the page size and base, and the offset comes from `walk_va`:
  - 01: `res_size` = 01 (64KB), base = bits [31:16], offset from `walk_va[15:0]`;
  - 10: `res_size` = 10 (4KB), base = bits [31:12], offset from `walk_va[11:0]`;
  - 11 from a fine table: `res_size` = 11 (1KB), base = bits [31:10], offset from `walk_va[9:0]`.
- R9: For page results, permission fields and the other attributes are filled as follows:
  - for 64KB and 4KB pages, `res_perm_all[2q+1:2q]` = descriptor bits [2q+5:2q+4] for q = 0..3;
  - for 1KB pages, all four fields repeat descriptor bits [5:4];
  - `res_domain` comes from first-level bits [8:5];
  - `res_c` and `res_b` come from second-level bits 3 and 2.
- R10: `res_perm` is the quarter field indexed by `walk_va[15:14]` for a 64KB page and by `walk_va[11:10]` for a 4KB page.
- R11: `done` is a one-cycle pulse in the cycle after the read data that ends the walk is accepted. `busy` is low in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| walk_req | input | 1 | Start a walk (taken only when idle) |
| walk_va | input | 32 | Modified virtual address to translate |
| tbase | input | 32 | Translation table base; bits [13:0] ignored |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Word address of the descriptor read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Descriptor read data |
| done | output | 1 | Result or fault is valid this cycle |
| res_fault | output | 2 | 00 none, 01 section fault, 10 page fault |
| res_size | output | 2 | 00 1MB, 01 64KB, 10 4KB, 11 1KB |
| res_base | output | 32 | Physical base of the mapped block |
| res_pa | output | 32 | Physical address for `walk_va` |
| res_domain | output | 4 | Domain number |
| res_perm_all | output | 8 | Four 2-bit quarter permission fields |
| res_perm | output | 2 | Permission field for this address |
| res_c | output | 1 | Cacheable attribute |
| res_b | output | 1 | Bufferable attribute |

## Verification
A wrong walk state shows up at the memory port in the very next cycle. It appears as a missing or extra fetch, or as an address built from the wrong table base or index width. A stale first-level descriptor or a wrong size decode does not show until the `done` pulse. It then appears as a wrong base mask, domain, or quarter permission. The sweep therefore covers every pairing of first- and second-level descriptor type across several addresses and memory latencies, and checks both fetch addresses and every result field on each walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [1:0] {
      PG_SECTION = 2'd0,
      PG_LARGE   = 2'd1,
      PG_SMALL   = 2'd2,
      PG_TINY    = 2'd3
   } pg_size_e;

   typedef enum logic [1:0] {
      WF_NONE    = 2'd0,
      WF_SECTION = 2'd1,
      WF_PAGE    = 2'd2
   } walk_fault_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_FIRST  = 2'd1,
      ST_SECOND = 2'd2
   } walk_state_e;

   localparam logic [1:0] L1_FAULT   = 2'b00;
   localparam logic [1:0] L1_COARSE  = 2'b01;
   localparam logic [1:0] L1_SECTION = 2'b10;
   localparam logic [1:0] L1_FINE    = 2'b11;

   localparam logic [1:0] L2_FAULT = 2'b00;
   localparam logic [1:0] L2_LARGE = 2'b01;
   localparam logic [1:0] L2_SMALL = 2'b10;
   localparam logic [1:0] L2_TINY  = 2'b11;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
   parameter int VA_W         = 32,
   parameter int L1_IDX_W     = 12,
   parameter int COARSE_IDX_W = 8,
   parameter int FINE_IDX_W   = 10
) (
   input  logic [VA_W-1:0] va,
   input  logic [VA_W-1:0] tbase,
   input  logic [VA_W-1:0] l1_desc,
   input  logic            fine_tbl,
   output logic [VA_W-1:0] first_addr,
   output logic [VA_W-1:0] second_addr
);
   localparam int WORD_LSB  = 2;
   localparam int SEC_OFF_W = VA_W - L1_IDX_W;
   localparam int TB_KEEP_W = VA_W - L1_IDX_W - WORD_LSB;
   localparam int CB_KEEP_W = VA_W - COARSE_IDX_W - WORD_LSB;
   localparam int FB_KEEP_W = VA_W - FINE_IDX_W - WORD_LSB;

   generate
      if (COARSE_IDX_W > SEC_OFF_W || FINE_IDX_W > SEC_OFF_W) begin : g_bad_idx
         $error("ptw_addr_gen: second-level index wider than section offset");
      end
   endgenerate

   logic [VA_W-1:0] coarse_addr;
   logic [VA_W-1:0] fine_addr;

   assign first_addr  = {tbase[VA_W-1 -: TB_KEEP_W], va[VA_W-1 -: L1_IDX_W], {WORD_LSB{1'b0}}};
   assign coarse_addr = {l1_desc[VA_W-1 -: CB_KEEP_W], va[SEC_OFF_W-1 -: COARSE_IDX_W],
                         {WORD_LSB{1'b0}}};
   assign fine_addr   = {l1_desc[VA_W-1 -: FB_KEEP_W], va[SEC_OFF_W-1 -: FINE_IDX_W],
                         {WORD_LSB{1'b0}}};
   assign second_addr = fine_tbl ? fine_addr : coarse_addr;

endmodule

// File: rtl/ptw_leaf_decode.sv
module ptw_leaf_decode
   import ptw_pkg::*;
#(
   parameter int VA_W        = 32,
   parameter int L1_IDX_W    = 12,
   parameter int DOM_W       = 4,
   parameter int AP_W        = 2,
   parameter int N_QTR       = 4,
   parameter int LARGE_OFF_W = 16,
   parameter int SMALL_OFF_W = 12,
   parameter int TINY_OFF_W  = 10
) (
   input  logic [VA_W-1:0]        va,
   input  logic [VA_W-1:0]        l1_desc,
   input  logic [VA_W-1:0]        leaf,
   input  logic                   is_page,
   output logic [VA_W-1:0]        base,
   output logic [VA_W-1:0]        pa,
   output logic [1:0]             size,
   output logic [DOM_W-1:0]       dom,
   output logic [N_QTR*AP_W-1:0]  perm_all,
   output logic [AP_W-1:0]        perm,
   output logic                   c_bit,
   output logic                   b_bit,
   output logic [1:0]             fault
);
   localparam int SEC_OFF_W   = VA_W - L1_IDX_W;
   localparam int QSEL_W      = $clog2(N_QTR);
   localparam int DOM_LO      = 5;
   localparam int PERM_LO     = 4;
   localparam int SEC_PERM_LO = 10;
   localparam int C_POS       = 3;
   localparam int B_POS       = 2;

   generate
      if (PERM_LO + N_QTR*AP_W > SEC_PERM_LO + AP_W) begin : g_bad_perm
         $error("ptw_leaf_decode: quarter permission fields overrun descriptor");
      end
      if (!(TINY_OFF_W < SMALL_OFF_W && SMALL_OFF_W < LARGE_OFF_W && LARGE_OFF_W < SEC_OFF_W))
      begin : g_bad_sizes
         $error("ptw_leaf_decode: page offsets must increase with page size");
      end
   endgenerate

   logic [1:0]        kind;
   logic              fine_tbl;
   logic              flt;
   pg_size_e          sz;
   logic [VA_W-1:0]   off_mask;
   logic [QSEL_W-1:0] qidx;

   assign kind     = leaf[1:0];
   assign fine_tbl = (l1_desc[1:0] == L1_FINE);

   always_comb begin
      flt   = 1'b0;
      sz    = PG_SECTION;
      fault = WF_NONE;
      if (!is_page) begin
         if (kind == L1_FAULT) begin
            flt   = 1'b1;
            fault = WF_SECTION;
         end
      end else begin
         case (kind)
            L2_FAULT: begin
               flt   = 1'b1;
               fault = WF_PAGE;
            end
            L2_LARGE: sz = PG_LARGE;
            L2_SMALL: sz = PG_SMALL;
            default: begin
               if (fine_tbl) begin
                  sz = PG_TINY;
               end else begin
                  flt   = 1'b1;
                  fault = WF_PAGE;
               end
            end
         endcase
      end
   end

   always_comb begin
      case (sz)
         PG_LARGE: off_mask = {VA_W{1'b1}} >> (VA_W - LARGE_OFF_W);
         PG_SMALL: off_mask = {VA_W{1'b1}} >> (VA_W - SMALL_OFF_W);
         PG_TINY:  off_mask = {VA_W{1'b1}} >> (VA_W - TINY_OFF_W);
         default:  off_mask = {VA_W{1'b1}} >> (VA_W - SEC_OFF_W);
      endcase
      case (sz)
         PG_LARGE: qidx = va[LARGE_OFF_W-1 -: QSEL_W];
         PG_SMALL: qidx = va[SMALL_OFF_W-1 -: QSEL_W];
         default:  qidx = '0;
      endcase
   end

   genvar q;
   generate
      for (q = 0; q < N_QTR; q++) begin : g_qtr
         assign perm_all[q*AP_W +: AP_W] =
            flt            ? '0 :
            !is_page       ? leaf[SEC_PERM_LO +: AP_W] :
            (sz == PG_TINY) ? leaf[PERM_LO +: AP_W] :
                              leaf[PERM_LO + q*AP_W +: AP_W];
      end
   endgenerate

   assign perm  = perm_all[qidx*AP_W +: AP_W];
   assign base  = flt ? '0 : (leaf & ~off_mask);
   assign pa    = flt ? '0 : ((leaf & ~off_mask) | (va & off_mask));
   assign size  = flt ? 2'b00 : sz;
   assign dom   = flt ? '0 : (is_page ? l1_desc[DOM_LO +: DOM_W] : leaf[DOM_LO +: DOM_W]);
   assign c_bit = flt ? 1'b0 : leaf[C_POS];
   assign b_bit = flt ? 1'b0 : leaf[B_POS];

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int VA_W         = 32,
   parameter int L1_IDX_W     = 12,
   parameter int COARSE_IDX_W = 8,
   parameter int FINE_IDX_W   = 10,
   parameter int DOM_W        = 4,
   parameter int AP_W         = 2,
   parameter int N_QTR        = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   walk_req,
   input  logic [VA_W-1:0]        walk_va,
   input  logic [VA_W-1:0]        tbase,
   output logic                   busy,
   output logic                   mem_req,
   output logic [VA_W-1:0]        mem_addr,
   input  logic                   mem_rvalid,
   input  logic [VA_W-1:0]        mem_rdata,
   output logic                   done,
   output logic [1:0]             res_fault,
   output logic [1:0]             res_size,
   output logic [VA_W-1:0]        res_base,
   output logic [VA_W-1:0]        res_pa,
   output logic [DOM_W-1:0]       res_domain,
   output logic [N_QTR*AP_W-1:0]  res_perm_all,
   output logic [AP_W-1:0]        res_perm,
   output logic                   res_c,
   output logic                   res_b
);
   generate
      if (VA_W != 32) begin : g_bad_va
         $error("ptw_walker: descriptor layout needs a 32-bit address");
      end
      if (N_QTR != 4 || AP_W != 2) begin : g_bad_qtr
         $error("ptw_walker: four 2-bit quarter permissions expected");
      end
   endgenerate

   walk_state_e            state_q;
   logic [VA_W-1:0]        va_q, tb_q, l1_q;
   logic [VA_W-1:0]        first_addr, second_addr;
   logic [VA_W-1:0]        d_base, d_pa;
   logic [1:0]             d_size, d_fault;
   logic [DOM_W-1:0]       d_dom;
   logic [N_QTR*AP_W-1:0]  d_perm_all;
   logic [AP_W-1:0]        d_perm;
   logic                   d_c, d_b;
   logic                   finish;

   ptw_addr_gen #(
      .VA_W(VA_W), .L1_IDX_W(L1_IDX_W),
      .COARSE_IDX_W(COARSE_IDX_W), .FINE_IDX_W(FINE_IDX_W)
   ) u_addr (
      .va(va_q), .tbase(tb_q), .l1_desc(l1_q),
      .fine_tbl(l1_q[1:0] == L1_FINE),
      .first_addr(first_addr), .second_addr(second_addr)
   );

   ptw_leaf_decode #(
      .VA_W(VA_W), .L1_IDX_W(L1_IDX_W), .DOM_W(DOM_W),
      .AP_W(AP_W), .N_QTR(N_QTR)
   ) u_dec (
      .va(va_q), .l1_desc(l1_q), .leaf(mem_rdata),
      .is_page(state_q == ST_SECOND),
      .base(d_base), .pa(d_pa), .size(d_size), .dom(d_dom),
      .perm_all(d_perm_all), .perm(d_perm), .c_bit(d_c), .b_bit(d_b),
      .fault(d_fault)
   );

   assign busy     = (state_q != ST_IDLE);
   assign mem_req  = busy;
   assign mem_addr = (state_q == ST_SECOND) ? second_addr : first_addr;

   always_comb begin
      finish = 1'b0;
      if (mem_rvalid) begin
         if (state_q == ST_SECOND) begin
            finish = 1'b1;
         end else if (state_q == ST_FIRST) begin
            finish = (mem_rdata[1:0] == L1_FAULT) || (mem_rdata[1:0] == L1_SECTION);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         va_q         <= '0;
         tb_q         <= '0;
         l1_q         <= '0;
         done         <= 1'b0;
         res_fault    <= '0;
         res_size     <= '0;
         res_base     <= '0;
         res_pa       <= '0;
         res_domain   <= '0;
         res_perm_all <= '0;
         res_perm     <= '0;
         res_c        <= 1'b0;
         res_b        <= 1'b0;
      end else begin
         done <= finish;
         if (finish) begin
            state_q      <= ST_IDLE;
            res_fault    <= d_fault;
            res_size     <= d_size;
            res_base     <= d_base;
            res_pa       <= d_pa;
            res_domain   <= d_dom;
            res_perm_all <= d_perm_all;
            res_perm     <= d_perm;
            res_c        <= d_c;
            res_b        <= d_b;
         end else begin
            case (state_q)
               ST_IDLE: begin
                  if (walk_req) begin
                     va_q    <= walk_va;
                     tb_q    <= tbase;
                     state_q <= ST_FIRST;
                  end
               end
               ST_FIRST: begin
                  if (mem_rvalid) begin
                     l1_q    <= mem_rdata;
                     state_q <= ST_SECOND;
                  end
               end
               default: state_q <= state_q;
            endcase
         end
      end
   end

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        busy,
   input logic        mem_req,
   input logic [31:0] mem_addr,
   input logic        mem_rvalid,
   input logic        done,
   input logic [1:0]  res_fault,
   input logic [1:0]  res_size,
   input logic [31:0] res_base
);
   AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);                                               // R1
   AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00));                             // R2
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));      // R3
   AST_FAULT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (done && res_fault != 2'b00) |-> (res_base == 32'h0));             // R4
   AST_SECTION_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (done && res_fault == 2'b00 && res_size == 2'b00) |-> (res_base[19:0] == 20'h0)); // R5
   AST_LARGE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (done && res_fault == 2'b00 && res_size == 2'b01) |-> (res_base[15:0] == 16'h0)); // R8
   AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(mem_rvalid && mem_req));                            // R11
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                   // R11
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);                                                   // R11
endmodule

bind ptw_walker ptw_walker_chk u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req),
   .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .done(done),
   .res_fault(res_fault), .res_size(res_size), .res_base(res_base)
);

// File: tb/ptw_walker_bench.sv
module ptw_walker_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        walk_req = 1'b0;
   logic [31:0] walk_va = '0;
   logic [31:0] tbase = '0;
   logic        busy, mem_req, done, res_c, res_b;
   logic [31:0] mem_addr, res_base, res_pa;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic [1:0]  res_fault, res_size, res_perm;
   logic [3:0]  res_domain;
   logic [7:0]  res_perm_all;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   ptw_walker u_ptw_walker (
      .clk(clk), .rst_n(rst_n), .walk_req(walk_req), .walk_va(walk_va),
      .tbase(tbase), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done),
      .res_fault(res_fault), .res_size(res_size), .res_base(res_base),
      .res_pa(res_pa), .res_domain(res_domain), .res_perm_all(res_perm_all),
      .res_perm(res_perm), .res_c(res_c), .res_b(res_b)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=<150000", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic walk(input logic [31:0] va, input logic [31:0] tb,
                       input logic [31:0] d1, input logic [31:0] d2, input int lat);
      logic [31:0] a1, a2, e_base, e_pa, omask;
      logic [1:0]  e_fault, e_size, e_perm;
      logic [7:0]  e_all;
      logic [3:0]  e_dom;
      logic        e_c, e_b, paged;
      int          qsel;
      a1    = (tb & 32'hFFFF_C000) | ((va >> 20) << 2);
      paged = d1[0];
      if (d1[1:0] == 2'b11)
         a2 = (d1 & 32'hFFFF_F000) | (((va >> 10) & 32'h3FF) << 2);
      else
         a2 = (d1 & 32'hFFFF_FC00) | (((va >> 12) & 32'hFF) << 2);

      e_fault = 2'b00; e_size = 2'b00; e_base = 0; e_pa = 0; e_dom = 0;
      e_all = 0; e_perm = 0; e_c = 0; e_b = 0; qsel = 0; omask = 0;
      if (d1[1:0] == 2'b00) begin
         e_fault = 2'b01;
      end else if (d1[1:0] == 2'b10) begin
         omask  = 32'h000F_FFFF;
         e_base = d1 & ~omask;
         e_pa   = e_base | (va & omask);
         e_dom  = d1[8:5];
         e_all  = {4{d1[11:10]}};
         e_perm = d1[11:10];
         e_c = d1[3]; e_b = d1[2];
      end else if (d2[1:0] == 2'b00 || (d2[1:0] == 2'b11 && d1[1:0] == 2'b01)) begin
         e_fault = 2'b10;
      end else begin
         e_size = d2[1:0];
         case (d2[1:0])
            2'b01:   begin omask = 32'h0000_FFFF; qsel = int'((va >> 14) & 3); end
            2'b10:   begin omask = 32'h0000_0FFF; qsel = int'((va >> 10) & 3); end
            default: begin omask = 32'h0000_03FF; qsel = 0; end
         endcase
         e_base = d2 & ~omask;
         e_pa   = e_base | (va & omask);
         e_dom  = d1[8:5];
         e_all  = (d2[1:0] == 2'b11) ? {4{d2[5:4]}} : d2[11:4];
         e_perm = 2'((e_all >> (2*qsel)) & 8'h3);
         e_c = d2[3]; e_b = d2[2];
      end

      @(negedge clk);
      walk_req = 1'b1; walk_va = va; tbase = tb;
      @(negedge clk);
      walk_req = 1'b0; walk_va = ~va; tbase = ~tb;
      check("R2 first mem_req", {31'b0, mem_req}, 32'd1);
      check("R2 first address", mem_addr, a1);
      for (int i = 0; i < lat; i++) begin
         @(negedge clk);
         check("R3 held request", {31'b0, mem_req}, 32'd1);
         check("R3 held address", mem_addr, a1);
      end
      mem_rvalid = 1'b1; mem_rdata = d1;
      @(negedge clk);
      mem_rvalid = 1'b0; mem_rdata = 32'hDEAD_BEEF;
      if (paged) begin
         check("R6 second mem_req", {31'b0, mem_req}, 32'd1);
         check("R6 second address", mem_addr, a2);
         check("R11 no early done", {31'b0, done}, 32'd0);
         for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            check("R3 held second address", mem_addr, a2);
         end
         mem_rvalid = 1'b1; mem_rdata = d2;
         @(negedge clk);
         mem_rvalid = 1'b0; mem_rdata = 32'hDEAD_BEEF;
      end else begin
         check("R4 no second fetch", {31'b0, mem_req}, 32'd0);
      end
      check("R11 done pulse", {31'b0, done}, 32'd1);
      check("R11 idle at done", {31'b0, busy}, 32'd0);
      check(d1[1:0] == 2'b00 ? "R4 fault code" : "R7 fault code", {30'b0, res_fault}, {30'b0, e_fault});
      check("R8 size", {30'b0, res_size}, {30'b0, e_size});
      check(paged ? "R8 base" : "R5 base", res_base, e_base);
      check(paged ? "R8 pa" : "R5 pa", res_pa, e_pa);
      check(paged ? "R9 domain" : "R5 domain", {28'b0, res_domain}, {28'b0, e_dom});
      check(paged ? "R9 perm fields" : "R5 perm fields", {24'b0, res_perm_all}, {24'b0, e_all});
      check("R10 selected perm", {30'b0, res_perm}, {30'b0, e_perm});
      check("R9 c/b", {30'b0, res_c, res_b}, {30'b0, e_c, e_b});
      @(negedge clk);
      check("R11 done one cycle", {31'b0, done}, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 busy after reset", {31'b0, busy}, 32'd0);
      check("R1 done after reset", {31'b0, done}, 32'd0);
      check("R1 mem_req after reset", {31'b0, mem_req}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle after release", {31'b0, mem_req}, 32'd0);

      for (int v = 0; v < 8; v++) begin
         for (int t1 = 0; t1 < 4; t1++) begin
            for (int t2 = 0; t2 < 4; t2++) begin
               logic [31:0] va, tb, d1, d2;
               va = 32'h9E37_79B9 * (v + 1) + 32'h0001_4400 * v;
               tb = 32'h6A09_E667 ^ (32'h0010_3FFF * (v + t1));
               d1 = ((32'hB7E1_5163 * (v + 3 * t1 + 1)) & ~32'h3) | 32'(t1);
               d2 = ((32'h2545_F491 * (v + 5 * t2 + 2)) & ~32'h3) | 32'(t2);
               walk(va, tb, d1, d2, (v + t1 + t2) % 3);
            end
         end
      end

      // every quarter of a 64KB and a 4KB page (R10)
      for (int q = 0; q < 4; q++) begin
         walk(32'h1234_0000 | (32'(q) << 14), 32'h0004_0000, 32'h8000_0131, 32'h4000_0E41, 0);
         walk(32'h1234_5000 | (32'(q) << 10), 32'h0004_0000, 32'h8000_0133, 32'h4000_1B32, 1);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule